// File: doc/BRIEF.md
# FFT Stage Scaling and Overflow Unit

This block sits between the butterfly datapath of a mixed radix-4/radix-2 FFT (8 to 4096 points) and the stage memory. A transform of 2^L points runs ceil(L/2) stages. Every stage but a lone final radix-2 stage is radix-4 and can grow by two bits. That lone stage exists when L is odd and grows by at most one bit. Each complex butterfly result arrives with two guard bits above the 16-bit sample format. The block shifts it right by that stage's programmed amount, rounds it, and clamps it back to 16 bits.

The transform length code and a packed schedule of 2-bit shift amounts are captured on a start pulse and held for the frame. A schedule that asks a lone radix-2 stage for more than one bit of shift is flagged as invalid. So is a length code outside the supported range. In both cases the block carries on with the nearest legal setting. Any result that did not fit in 16 bits raises a sticky overflow flag, which tells the host to discard the frame and raise the scaling.

Top module: `fft_stage_scaler`

## Requirements
- R1: `len_code` and `sched` are captured on a cycle with `start` high and are used until the next start. A sample presented in the start cycle already uses the new values. Changing these inputs without `start` has no effect on later outputs.
- R2: The shift for stage index s is the field `sched[2s+1:2s]`, with stage 0 in bits [1:0]. A stage index with no field in the 12-bit vector (6 or 7) uses a shift of 0.
- R3: The shift is arithmetic and rounds half up: the result is floor((x + 2^(k-1)) / 2^k) for shift k>0, and x unchanged for k=0.
- R4: A rounded value above 32767 is output as 32767, and one below -32768 as -32768, on each of the real and imaginary parts independently.
- R5: `ovf` rises in the cycle after a valid sample that needed clamping, and stays high until a start. A start with no saturating sample in the same cycle clears it, and a saturating sample in the start cycle sets it again.
- R6: For an odd length code L, the field of the last stage, index (L-1)/2, may hold only 0 or 1. A value of 2 or 3 there sets `sched_err` after the start and makes that stage shift by 1.
- R7: A length code below 3 or above 12 sets `sched_err`. The code is then treated as 3 or 12 respectively. `sched_err` is cleared by a start with a legal configuration.
- R8: `out_valid` follows `in_valid` with one cycle of latency. While `out_valid` is low, `out_re` and `out_im` hold their last values.
- R9: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | Frame start; captures length and schedule, clears overflow |
| len_code | input | 4 | log2 of the transform length |
| sched | input | 12 | Packed 2-bit shift per stage, stage 0 in the LSBs |
| stage | input | 3 | Stage index of the present butterfly result |
| in_valid | input | 1 | Butterfly result valid |
| in_re | input | 18 | Real part, signed, with two guard bits |
| in_im | input | 18 | Imaginary part, signed, with two guard bits |
| out_valid | output | 1 | Scaled result valid |
| out_re | output | 16 | Scaled, saturated real part |
| out_im | output | 16 | Scaled, saturated imaginary part |
| ovf | output | 1 | Sticky overflow for the current frame |
| sched_err | output | 1 | Invalid schedule or length captured at the last start |

## Verification
The bench drives negative odd values across shifts of 1 to 3. A design that truncated, or rounded symmetrically, would be off by one on results such as -5 shifted by 1, which must give -2. It exercises an odd length whose last field holds 3. A design that trusted the field would shift two bits too many, and one that ignored the check would leave `sched_err` low. It changes the schedule input mid-frame to catch a design that samples it live. It also lets overflow occur both before and within a start cycle, which exposes a flag that does not stick or that clears at the wrong time.

// File: rtl/fft_stage_scaler.sv
module fft_stage_scaler #(
  parameter int DW = 16,
  parameter int GW = 2,
  parameter int LW = 4,
  parameter int MINLOG = 3,
  parameter int MAXLOG = 12,
  localparam int NST = (MAXLOG + 1) / 2,
  localparam int SW = 2 * NST,
  localparam int STW = $clog2(NST + 1),
  localparam int IW = DW + GW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [LW-1:0]        len_code,
  input  logic [SW-1:0]        sched,
  input  logic [STW-1:0]       stage,
  input  logic                 in_valid,
  input  logic signed [IW-1:0] in_re,
  input  logic signed [IW-1:0] in_im,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im,
  output logic                 ovf,
  output logic                 sched_err
);

  localparam logic signed [IW:0] POS_LIM = (IW+1)'((2 ** (DW - 1)) - 1);
  localparam logic signed [IW:0] NEG_LIM = -(IW+1)'(2 ** (DW - 1));

  logic [LW-1:0] len_q, len_new, len_act;
  logic [SW-1:0] sched_q, sched_act;
  logic          range_bad, top_bad;
  logic [1:0]    shamt;

  always_comb begin
    int lc;
    lc = int'(len_code);
    range_bad = (lc < MINLOG) || (lc > MAXLOG);
    if (lc < MINLOG)      len_new = LW'(MINLOG);
    else if (lc > MAXLOG) len_new = LW'(MAXLOG);
    else                  len_new = len_code;
  end

  assign top_bad = len_new[0] &&
    (((sched >> (2 * ((int'(len_new) - 1) / 2))) & SW'(2)) != '0);

  assign len_act   = start ? len_new : len_q;
  assign sched_act = start ? sched   : sched_q;

  always_comb begin
    logic [1:0] fld;
    fld = 2'(sched_act >> (2 * int'(stage)));
    if (len_act[0] && (int'(stage) == (int'(len_act) - 1) / 2) && fld[1])
      shamt = 2'd1;
    else
      shamt = fld;
  end

  function automatic logic [DW:0] scale_sat(input logic signed [IW-1:0] x,
                                            input logic [1:0] k);
    logic signed [IW:0] ext, rnd, shd;
    ext = {x[IW-1], x};
    rnd = (k == 2'd0) ? '0 : (IW+1)'(1) <<< (k - 2'd1);
    shd = (ext + rnd) >>> k;
    if (shd > POS_LIM)      return {1'b1, POS_LIM[DW-1:0]};
    else if (shd < NEG_LIM) return {1'b1, NEG_LIM[DW-1:0]};
    else                    return {1'b0, shd[DW-1:0]};
  endfunction

  logic [DW:0] re_s, im_s;
  assign re_s = scale_sat(in_re, shamt);
  assign im_s = scale_sat(in_im, shamt);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      len_q     <= LW'(MINLOG);
      sched_q   <= '0;
      sched_err <= 1'b0;
    end else if (start) begin
      len_q     <= len_new;
      sched_q   <= sched;
      sched_err <= range_bad | top_bad;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
      ovf       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_re <= re_s[DW-1:0];
        out_im <= im_s[DW-1:0];
      end
      ovf <= (ovf & ~start) | (in_valid & (re_s[DW] | im_s[DW]));
    end
  end

endmodule

// File: rtl/fft_stage_scaler_chk.sv
module fft_stage_scaler_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic in_valid,
  input logic out_valid,
  input logic ovf,
  input logic sched_err
);

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !start) |=> ovf); // R5

  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (start && !in_valid) |=> !ovf); // R5

  AST_OVF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!ovf && !in_valid) |=> !ovf); // R5

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R8

  AST_VALID_FALL: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R8

  AST_ERR_HELD: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(sched_err)); // R1

endmodule

bind fft_stage_scaler fft_stage_scaler_chk u_chk (.*);

// File: tb/fft_stage_scaler_bench.sv
module fft_stage_scaler_bench;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 0, in_valid = 0;
  logic [3:0] len_code = 0;
  logic [11:0] sched = 0;
  logic [2:0] stage = 0;
  logic signed [17:0] in_re = 0, in_im = 0;
  logic out_valid, ovf, sched_err;
  logic signed [15:0] out_re, out_im;

  fft_stage_scaler u_fft_stage_scaler (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int m_len = 3, m_sched = 0, m_err = 0, m_ovf = 0;
  int m_re = 0, m_im = 0, m_v = 0;

  function automatic int scl(int x, int k);
    if (k == 0) return x;
    return (x + (1 << (k - 1))) >>> k;
  endfunction

  function automatic int sat(int x, inout int o);
    if (x > 32767) begin o = 1; return 32767; end
    if (x < -32768) begin o = 1; return -32768; end
    return x;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (out_valid !== m_v[0] || int'(out_re) != m_re || int'(out_im) != m_im ||
        ovf !== m_ovf[0] || sched_err !== m_err[0]) begin
      fails++;
      $display("FAIL %s: v/re/im/ovf/err = %0d/%0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d/%0d",
               tag, out_valid, out_re, out_im, ovf, sched_err,
               m_v, m_re, m_im, m_ovf, m_err);
    end
  endtask

  task automatic step(bit st, int ln, int sc, bit v, int sg, int re, int im, string tag);
    int eff, f, o;
    start = st; len_code = 4'(ln); sched = 12'(sc); in_valid = v;
    stage = 3'(sg); in_re = 18'(re); in_im = 18'(im);
    if (st) begin
      m_err = (ln < 3 || ln > 12) ? 1 : 0;
      m_len = ln < 3 ? 3 : (ln > 12 ? 12 : ln);
      m_sched = sc;
      if ((m_len % 2) == 1 && ((sc >> (2 * ((m_len - 1) / 2))) & 3) > 1) m_err = 1;
      m_ovf = 0;
    end
    eff = m_len;
    f = (m_sched >> (2 * sg)) & 3;
    if ((eff % 2) == 1 && sg == (eff - 1) / 2 && f > 1) f = 1;
    m_v = v;
    if (v) begin
      o = 0;
      m_re = sat(scl(re, f), o);
      m_im = sat(scl(im, f), o);
      if (o != 0) m_ovf = 1;
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    compare("R9 reset");
    rst = 0;
    @(negedge clk);
    compare("R9 after release");
    // even length 8, fields s0=0 s1=1 s2=2 s3=3
    step(1, 8, 12'h0E4, 1, 0, 5, -5, "R1 start-cycle sample");
    step(0, 8, 12'h0E4, 1, 1, 5, -5, "R3 shift1 half-up");
    step(0, 8, 12'h0E4, 1, 1, 6, -7, "R3 shift1");
    step(0, 8, 12'h0E4, 1, 2, 7, -6, "R2 stage2 shift2");
    step(0, 8, 12'h0E4, 1, 2, -2, 2, "R3 shift2 tie");
    step(0, 8, 12'h0E4, 1, 3, -12, 131071, "R2 stage3 shift3");
    step(0, 8, 12'h0E4, 1, 3, -131072, -4, "R3 shift3 negative");
    step(0, 8, 12'h000, 1, 3, 100, -100, "R1 schedule change ignored");
    step(0, 5, 12'hFFF, 1, 1, 9, 9, "R1 length change ignored");
    step(0, 8, 12'h0E4, 0, 0, 1234, 1234, "R8 hold when idle");
    step(0, 8, 12'h0E4, 1, 0, 32767, -32768, "R4 exact limits");
    step(0, 8, 12'h0E4, 1, 0, 40000, 3, "R4 positive clamp");
    step(0, 8, 12'h0E4, 1, 0, 7, -40000, "R4 negative clamp");
    step(0, 8, 12'h0E4, 0, 0, 0, 0, "R5 sticky");
    step(0, 8, 12'h0E4, 1, 1, 2, 2, "R5 sticky with clean data");
    step(1, 8, 12'h0E4, 0, 0, 0, 0, "R5 start clears");
    step(0, 8, 12'h0E4, 1, 3, 131071, -131072, "R5 no ovf after shift3");
    step(1, 8, 12'h0E4, 1, 0, 65536, 0, "R5 saturating start sample");
    step(0, 8, 12'h0E4, 1, 6, 33000, -5, "R2 stage6 shift0");
    // odd length 9, last stage index 4
    step(1, 9, 12'h300, 1, 4, 101, -101, "R6 bad last field shift1");
    step(0, 9, 12'h300, 1, 4, 131071, 3, "R6 clamp shift");
    step(1, 9, 12'h1AA, 1, 4, 101, -3, "R6 legal last field");
    step(0, 9, 12'h1AA, 1, 3, 101, -3, "R6 inner stage shift2");
    step(1, 11, 12'h800, 1, 5, 50, 51, "R6 length11 field5=2");
    step(1, 12, 12'hC00, 1, 5, 50, 51, "R6 even length field5=3 legal");
    // out of range lengths
    step(1, 2, 12'h00C, 1, 1, 21, -21, "R7 length2 treated as 3");
    step(0, 2, 12'h00C, 1, 0, 21, -21, "R7 stage0");
    step(1, 13, 12'hC00, 1, 5, 21, -21, "R7 length13 treated as 12");
    step(1, 0, 12'h000, 1, 1, 5, 5, "R7 length0");
    step(1, 15, 12'h555, 1, 2, 5, 5, "R7 length15");
    step(1, 10, 12'h555, 1, 4, 5, 5, "R7 error cleared");
    step(0, 10, 12'h555, 0, 4, 0, 0, "R8 valid drop");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule